// File: doc/BRIEF.md
# Flow-through synchronous SRAM with no bus turnaround

This block models a synchronous static memory for use inside a larger chip. Address, operation and chip selection are captured on the rising clock edge. Read data is not held in an output register: it comes straight from the array onto the output port during the cycle after the edge that captured the read. Write data follows its address by one cycle and is stored at the next accepted edge. A read may therefore follow a write, and a write may follow a read, on consecutive cycles with no idle cycle between them, and a read of a word that was just written returns the new value.

Every access is either a single cycle or a burst of up to four beats. A load cycle captures a full address; its two low bits give the starting offset within an aligned group of four words. Each advance cycle then moves a two-bit beat count forward. The effective low address bits come from the start offset and the beat count, in either linear or exclusive-or order, chosen by a static order input. Each data lane has its own write enable. Three chip selects allow several devices to share a bus. A clock enable freezes the block, and an asynchronous doze input shuts off the outputs and ends any access.

The bidirectional data bus is split into an input port, an output port and an output-enable port. The enclosing pad logic combines them.

Top module: `flow_sram`

## Requirements
- R1: After reset no access is active and `rdata_en` stays low until a selected load cycle captures a read.
- R2: A read captured at a rising edge makes `rdata` equal to the stored word at the effective address during the following clock cycle, with no extra register stage. `rdata_en` is high in that cycle while `drive_en` is high and `doze` is low.
- R3: A write (`is_write`=1 on a selected load) takes `wdata` during the following cycle and stores it at the next accepted edge. Writes and reads may alternate on consecutive cycles with no idle cycle, and a read captured at that same edge returns the new data.
- R4: `lane_wr[i]` enables bits [i*LANE_W +: LANE_W] of a write beat, and lanes whose enable is 0 keep their contents. `rdata_en` is never high while a write access is active.
- R5: A load cycle starts an access only when `sel_a`=1, `sel_b`=1 and `sel_n`=0. Otherwise the block is deselected: it drives nothing, and the `wdata` offered next is not stored.
- R6: While `run`=0 the rising edge is ignored. The active access, the burst beat, the lane enables and any pending write data slot stay unchanged, and a load offered in that cycle is dropped.
- R7: A load (`advance`=0) sets the beat count to 0 and the start offset to `addr[1:0]`, and keeps `addr[ADDR_W-1:2]` as the fixed upper address. Each advance (`advance`=1) steps the beat count modulo 4 and samples `lane_wr` again for that beat. An advance with no active access does nothing.
- R8: With `order_xor`=0 the low address bits are (start + beat) mod 4, for example 1,2,3,0. With `order_xor`=1 they are start XOR beat, for example 1,0,3,2.
- R9: `drive_en` acts on `rdata_en` without waiting for a clock edge.
- R10: `doze`=1 forces `rdata_en` low at once. An edge seen while dozing ends the active access and stores no write. After doze, advance cycles produce nothing until a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| run | input | 1 | Clock enable; 0 freezes the block |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| advance | input | 1 | 1 = advance the burst, 0 = load a new address |
| is_write | input | 1 | Operation on a load: 1 = write, 0 = read |
| lane_wr | input | LANES | Per-lane write enables |
| addr | input | ADDR_W | Word address, captured on load |
| drive_en | input | 1 | Asynchronous output enable |
| order_xor | input | 1 | Burst order: 0 linear, 1 exclusive-or |
| doze | input | 1 | Asynchronous power-down |
| wdata | input | LANES*LANE_W | Write data, one cycle after its address |
| rdata | output | LANES*LANE_W | Read data, flowing from the array |
| rdata_en | output | 1 | Enable for the external data drivers |

## Verification
The bench builds the block with ADDR_W=4, LANES=2 and LANE_W=8, so the whole 16-word array can be filled, read back and rewritten in interleaved write/read pairs. That small size also lets the bench try every start offset in both burst orders, several lane-enable patterns within one burst, and all seven deselecting chip-select combinations. Expected words and addresses come from an arithmetic model of the burst order and the one-cycle write data delay. Suspension, asynchronous output enable and doze are inserted in the middle of accesses to check that state is held or cleared.

// File: rtl/flow_sram_pkg.sv
package flow_sram_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef enum logic {
        ORD_LIN = 1'b0,
        ORD_XOR = 1'b1
    } ord_e;

    localparam int BEAT_W = 2;

endpackage

// File: rtl/flow_sram_ctrl.sv
module flow_sram_ctrl
    import flow_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                doze,
    input  logic                advance,
    input  logic                sel_ok,
    input  logic                is_write,
    input  logic [LANES-1:0]    lane_wr,
    input  logic [ADDR_W-1:0]   addr,
    output logic                act,
    output op_e                 op,
    output logic [ADDR_W-3:0]   base,
    output logic [BEAT_W-1:0]   start,
    output logic [BEAT_W-1:0]   beat,
    output logic [LANES-1:0]    lanes
);

    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              act;
        op_e               op;
        logic [HI_W-1:0]   base;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        logic [LANES-1:0]  lanes;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (doze) begin
            st_d.act = 1'b0;
        end else if (run) begin
            if (!advance) begin
                if (sel_ok) begin
                    st_d.act   = 1'b1;
                    st_d.op    = is_write ? OP_WR : OP_RD;
                    st_d.base  = addr[ADDR_W-1:BEAT_W];
                    st_d.start = addr[BEAT_W-1:0];
                    st_d.beat  = '0;
                    st_d.lanes = lane_wr;
                end else begin
                    st_d.act = 1'b0;
                end
            end else if (st_q.act) begin
                st_d.beat  = st_q.beat + BEAT_W'(1);
                st_d.lanes = lane_wr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act   = st_q.act;
    assign op    = st_q.op;
    assign base  = st_q.base;
    assign start = st_q.start;
    assign beat  = st_q.beat;
    assign lanes = st_q.lanes;

endmodule

// File: rtl/flow_sram_burst.sv
module flow_sram_burst
    import flow_sram_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_xor,
    output logic [BEAT_W-1:0] offset
);

    logic [BEAT_W-1:0] lin_off;
    logic [BEAT_W-1:0] xor_off;

    always_comb begin
        lin_off = start + beat;
        xor_off = start ^ beat;
        offset  = (ord_e'(order_xor) == ORD_XOR) ? xor_off : lin_off;
    end

endmodule

// File: rtl/flow_sram_array.sv
module flow_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [LANES-1:0]         lane_en,
    input  logic [ADDR_W-1:0]        word,
    input  logic [LANES*LANE_W-1:0]  din,
    output logic [LANES*LANE_W-1:0]  dout
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                cells[word] <= din[g*LANE_W +: LANE_W];
            end
        end

        assign dout[g*LANE_W +: LANE_W] = cells[word];
    end

endmodule

// File: rtl/flow_sram.sv
module flow_sram
    import flow_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     sel_a,
    input  logic                     sel_b,
    input  logic                     sel_n,
    input  logic                     advance,
    input  logic                     is_write,
    input  logic [LANES-1:0]         lane_wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     drive_en,
    input  logic                     order_xor,
    input  logic                     doze,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_en
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              sel_ok;
    logic              st_act;
    op_e               st_op;
    logic              st_wr;
    logic [HI_W-1:0]   st_base;
    logic [BEAT_W-1:0] st_start;
    logic [BEAT_W-1:0] st_beat;
    logic [BEAT_W-1:0] st_off;
    logic [LANES-1:0]  st_lanes;
    logic [ADDR_W-1:0] eff_addr;
    logic              commit;

    assign sel_ok = sel_a & sel_b & ~sel_n;

    flow_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .doze     (doze),
        .advance  (advance),
        .sel_ok   (sel_ok),
        .is_write (is_write),
        .lane_wr  (lane_wr),
        .addr     (addr),
        .act      (st_act),
        .op       (st_op),
        .base     (st_base),
        .start    (st_start),
        .beat     (st_beat),
        .lanes    (st_lanes)
    );

    flow_sram_burst u_burst (
        .start     (st_start),
        .beat      (st_beat),
        .order_xor (order_xor),
        .offset    (st_off)
    );

    assign eff_addr = {st_base, st_off};
    assign st_wr    = (st_op == OP_WR);
    assign commit   = run & ~doze & st_act & st_wr;

    flow_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .we      (commit),
        .lane_en (st_lanes),
        .word    (eff_addr),
        .din     (wdata),
        .dout    (rdata)
    );

    assign rdata_en = drive_en & ~doze & st_act & ~st_wr;

endmodule

// File: rtl/flow_sram_chk.sv
module flow_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       doze,
    input logic       advance,
    input logic       sel_a,
    input logic       sel_b,
    input logic       sel_n,
    input logic       drive_en,
    input logic       rdata_en,
    input logic       st_act,
    input logic       st_wr,
    input logic [1:0] st_beat
);

    // R6: a suspended edge holds the access and its beat
    p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !doze) |=> ($stable(st_act) && $stable(st_beat)));

    // R10: an edge seen while dozing ends the access
    p_doze_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> !st_act);

    // R5: a deselected load leaves the outputs undriven
    p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !doze && !advance && !(sel_a && sel_b && !sel_n)) |=> !rdata_en);

    // R7: a selected load starts at beat zero
    p_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !doze && !advance && sel_a && sel_b && !sel_n) |=> (st_act && st_beat == 2'd0));

    // R7: an advance steps the beat by one
    p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !doze && advance && st_act) |=> (st_beat == $past(st_beat) + 2'd1));

    // R4: a write access never enables the drivers
    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_act && st_wr) |-> !rdata_en);

    // R9: drivers stay off while the output enable is low
    p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> !rdata_en);

endmodule

bind flow_sram flow_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .doze     (doze),
    .advance  (advance),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .sel_n    (sel_n),
    .drive_en (drive_en),
    .rdata_en (rdata_en),
    .st_act   (st_act),
    .st_wr    (st_wr),
    .st_beat  (st_beat)
);

// File: tb/flow_sram_bench.sv
`timescale 1ns/1ps
module flow_sram_bench;

    localparam int AW    = 4;
    localparam int LN    = 2;
    localparam int LW    = 8;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL_ON = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          sel_a = 1'b0;
    logic          sel_b = 1'b0;
    logic          sel_n = 1'b1;
    logic          advance = 1'b0;
    logic          is_write = 1'b0;
    logic [LN-1:0] lane_wr = '0;
    logic [AW-1:0] addr = '0;
    logic          drive_en = 1'b1;
    logic          order_xor = 1'b0;
    logic          doze = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    always #4 clk = ~clk;

    flow_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_flow_sram (
        .clk(clk), .rst_n(rst_n), .run(run), .sel_a(sel_a), .sel_b(sel_b),
        .sel_n(sel_n), .advance(advance), .is_write(is_write), .lane_wr(lane_wr),
        .addr(addr), .drive_en(drive_en), .order_xor(order_xor), .doze(doze),
        .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference state, built from the requirements
    logic            m_act = 1'b0;
    logic            m_wr = 1'b0;
    logic [AW-3:0]   m_base = '0;
    logic [1:0]      m_start = '0;
    logic [1:0]      m_beat = '0;
    logic [LN-1:0]   m_lanes = '0;
    logic [DW-1:0]   mem [DEPTH];

    function automatic logic [AW-1:0] eff();
        logic [1:0] o;
        o = order_xor ? (m_start ^ m_beat) : (m_start + m_beat);
        return {m_base, o};
    endfunction

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 16'h1357) ^ 16'h2a5c;
    endfunction

    task automatic chk(input string tag);
        logic en;
        logic [AW-1:0] ea;
        en = m_act && !m_wr && drive_en && !doze;
        ea = eff();
        n_chk++;
        if (rdata_en !== en) begin
            n_fail++;
            $display("FAIL %s: rdata_en=%0b expected %0b", tag, rdata_en, en);
        end
        if (en) begin
            n_chk++;
            if (rdata !== mem[ea]) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h (word %0d)", tag, rdata, mem[ea], ea);
            end
        end
    endtask

    task automatic tick(input logic adv, input logic w, input logic [LN-1:0] be,
                        input logic [AW-1:0] a, input logic [2:0] s, input logic ce,
                        input logic [DW-1:0] din, input string tag);
        logic [AW-1:0] wa;
        @(negedge clk);
        advance = adv; is_write = w; lane_wr = be; addr = a;
        {sel_a, sel_b, sel_n} = s; run = ce; wdata = din;
        @(posedge clk);
        if (doze) begin
            m_act = 1'b0;
        end else if (ce) begin
            if (m_act && m_wr) begin
                wa = eff();
                for (int l = 0; l < LN; l++)
                    if (m_lanes[l]) mem[wa][l*LW +: LW] = din[l*LW +: LW];
            end
            if (!adv) begin
                if (s == SEL_ON) begin
                    m_act = 1'b1; m_wr = w; m_base = a[AW-1:2];
                    m_start = a[1:0]; m_beat = '0; m_lanes = be;
                end else begin
                    m_act = 1'b0;
                end
            end else if (m_act) begin
                m_beat = m_beat + 2'd1;
                m_lanes = be;
            end
        end
        #1;
        chk(tag);
    endtask

    task automatic ld(input logic [AW-1:0] a, input logic w, input logic [LN-1:0] be,
                      input logic [DW-1:0] din, input string tag);
        tick(1'b0, w, be, a, SEL_ON, 1'b1, din, tag);
    endtask

    task automatic adv(input logic [LN-1:0] be, input logic [DW-1:0] din, input string tag);
        tick(1'b1, 1'b0, be, '0, SEL_ON, 1'b1, din, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected at most 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        k = 1;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 reset idle");
        tick(1'b1, 1'b0, '0, '0, SEL_ON, 1'b1, '0, "R1 R7 advance with nothing loaded");

        // fill with back-to-back writes, then a read of the last word at once
        for (int a = 0; a < DEPTH; a++)
            ld(AW'(a), 1'b1, '1, pat(a - 1), "R3 fill write");
        ld(AW'(DEPTH - 1), 1'b0, '0, pat(DEPTH - 1), "R3 read right after write");

        for (int a = 0; a < DEPTH; a++)
            ld(AW'(a), 1'b0, '0, '0, "R2 single read");

        // write/read pairs with no idle cycle
        for (int a = 0; a < DEPTH; a++) begin
            ld(AW'(a), 1'b1, '1, '0, "R3 write load");
            ld(AW'(a), 1'b0, '0, pat(a + 100), "R3 read after write no idle");
        end

        // bursts in both orders from every start offset
        for (int o = 0; o < 2; o++) begin
            for (int st = 0; st < 4; st++) begin
                logic [AW-1:0] a;
                order_xor = o[0];
                a = {2'(st + o), 2'(st)};
                ld(a, 1'b1, '1, '0, "R7 write burst load");
                adv(2'b11, pat(k), "R8 write beat 1"); k++;
                adv(2'b01, pat(k), "R4 R8 write beat 2"); k++;
                adv(2'b10, pat(k), "R4 R8 write beat 3"); k++;
                ld(a, 1'b0, '0, pat(k), "R8 read burst load"); k++;
                adv('0, '0, "R8 read beat 1");
                adv('0, '0, "R8 read beat 2");
                adv('0, '0, "R8 read beat 3");
                adv('0, '0, "R7 beat wraps to start");
            end
        end
        order_xor = 1'b0;

        // lane enables
        ld(AW'(5), 1'b1, 2'b01, '0, "R4 lane 0 write");
        ld(AW'(5), 1'b1, 2'b10, 16'h1111, "R4 lane 1 write");
        ld(AW'(5), 1'b1, 2'b00, 16'h2222, "R4 no lane write");
        ld(AW'(5), 1'b0, '0, 16'h3333, "R4 lane merge readback");

        // chip selects
        for (int s = 0; s < 8; s++) begin
            if (s != 6) begin
                tick(1'b0, 1'b1, '1, AW'(3), 3'(s), 1'b1, '0, "R5 deselected write load");
                tick(1'b0, 1'b0, '0, AW'(3), 3'(s), 1'b1, 16'hDEAD, "R5 deselected read load");
                ld(AW'(3), 1'b0, '0, '0, "R5 contents unchanged");
            end
        end

        // clock enable
        ld(AW'(8), 1'b0, '0, '0, "R6 read load");
        adv('0, '0, "R6 beat 1");
        tick(1'b1, 1'b0, '0, '0, SEL_ON, 1'b0, '0, "R6 suspended advance holds beat");
        tick(1'b0, 1'b0, '0, AW'(12), SEL_ON, 1'b0, '0, "R6 suspended load ignored");
        adv('0, '0, "R6 resume advance");
        ld(AW'(9), 1'b1, '1, '0, "R6 write load");
        tick(1'b1, 1'b0, '1, '0, SEL_ON, 1'b0, 16'hBAD0, "R6 suspended write data not taken");
        ld(AW'(9), 1'b0, '0, 16'h5A5A, "R6 write stored on resume");

        // asynchronous output enable
        ld(AW'(10), 1'b0, '0, '0, "R9 read load");
        @(negedge clk);
        drive_en = 1'b0;
        #1 chk("R9 output enable off");
        drive_en = 1'b1;
        #1 chk("R9 output enable on");

        // doze
        ld(AW'(11), 1'b0, '0, '0, "R10 read load");
        @(negedge clk);
        doze = 1'b1;
        #1 chk("R10 doze drops drivers");
        tick(1'b1, 1'b0, '0, '0, SEL_ON, 1'b1, '0, "R10 edge in doze");
        ld(AW'(12), 1'b0, '0, '0, "R10 load in doze refused");
        doze = 1'b0;
        adv('0, '0, "R10 advance after doze idle");
        ld(AW'(12), 1'b1, '1, '0, "R10 write load");
        doze = 1'b1;
        tick(1'b1, 1'b0, '1, '0, SEL_ON, 1'b1, 16'hF00D, "R10 doze blocks write");
        doze = 1'b0;
        ld(AW'(12), 1'b0, '0, '0, "R10 old data kept");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule